// File: doc/BRIEF.md
# Vendor Setup-Packet Firmware-Download Decoder

This block sits behind the default control endpoint of a USB device and answers a small set of vendor requests in hardware, so that a host can load firmware before any firmware runs. It looks at each 8-byte setup packet as it arrives. It turns flash program and flash fetch requests into single-cycle strobes for a flash access engine, which receive a 16-bit address and a data byte. It returns a fixed 32-bit chip identifier, and it can latch a bit that holds the embedded CPU.

Each answer is a one-cycle response strobe with the response bytes and their length, which the USB transport then carries in the data and status stages. A setup packet that is a vendor request but that the block does not recognise, or whose fields are inconsistent, raises a one-cycle stall. When the firmware-ready input is high, the block stays silent and firmware answers every request.

Setup bytes arrive packed little-end first: byte 0 (request type) is in bits 7:0, byte 1 (request code) is in bits 15:8, and so on up to byte 7 in bits 63:56. The two-byte fields value, index and length are little-endian.

Top module: `fwdl_setup_decoder`

## Requirements
- R1: After reset, flashWrReq, flashRdReq, respValid, stall and holdCpu are all 0.
- R2: Request type 0x40 with request code 0x61 and length 0 is a flash program request. Code 0x61 means bit 7 = 0 (flash), bit 6 = 1 (address valid), bit 5 = 1 (data valid) and bits 4:0 = 01h. flashWrReq is high for exactly the one cycle after the setup strobe. In that cycle flashAddr equals the value field ({byte3, byte2}) and flashWrData equals byte 4.
- R3: A flash program request gets no response until flashAck is sampled high. In the cycle after that sample, respValid pulses with respLen 0.
- R4: Request type 0xC0 with length 1 is a flash fetch request when bit 7 of the code is 0, bit 6 is 1 and bits 4:0 are 02h. Bit 5 is ignored. flashRdReq pulses for one cycle with flashAddr = {byte3, byte2}. respValid stays low until flashAck is sampled. It then pulses with respLen 1 and respBytes[7:0] equal to flashRdData as sampled with the acknowledge.
- R5: Request type 0xC0 with code 0x03 and length 4 gives, one cycle after the strobe, a respValid pulse with respLen 4 and respBytes = 0x29C51510. The least significant byte goes out first, so respBytes[7:0] = 0x10.
- R6: Request type 0x40 with code 0x04 sets holdCpu, and holdCpu stays set until reset. In the cycle after the strobe, respValid pulses with respLen 0.
- R7: A setup packet with request type 0x40 or 0xC0 that matches none of R2, R4, R5 or R6 raises stall for exactly the one cycle after the strobe, and no other strobe.
- R8: While fwReady is 1, a setup strobe produces no request strobe, response, stall or change of holdCpu.
- R9: A request type other than 0x40 and 0xC0 produces neither stall nor any other output.
- R10: A setup strobe that arrives while a flash access is waiting for its acknowledge is ignored. The pending access completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupValid | input | 1 | One-cycle strobe: setupBytes holds a new setup packet |
| setupBytes | input | 64 | Setup packet, byte 0 in bits 7:0 |
| fwReady | input | 1 | 1 = firmware answers control requests |
| flashAck | input | 1 | Flash engine finished the requested access |
| flashRdData | input | 8 | Byte fetched from flash, valid with flashAck |
| flashWrReq | output | 1 | One-cycle flash program request |
| flashRdReq | output | 1 | One-cycle flash fetch request |
| flashAddr | output | 16 | Flash address for the request |
| flashWrData | output | 8 | Byte to program |
| respValid | output | 1 | One-cycle strobe: response ready |
| respBytes | output | 32 | Response data, first byte in bits 7:0 |
| respLen | output | 3 | Number of valid response bytes |
| holdCpu | output | 1 | Sticky CPU hold |
| stall | output | 1 | One-cycle stall of the control transfer |

## Verification
The bench holds off the flash acknowledge for several cycles. A decoder that answered a fetch before the data existed would show respValid early, with a stale byte. It sends near-miss codes: a program code with address-valid clear, and a fetch with a length of 2. A loose field compare would start a flash access there instead of stalling. It checks the byte order of the chip identifier, which a reversed packing would get wrong in byte 0. It also sends packets while firmware is ready, while a standard request type is present, and while an access is still pending. In those cases a design that ignored the ready flag, stalled standard requests or restarted on a second strobe would emit a strobe the bench does not expect.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

  localparam int SETUP_BYTES = 8;
  localparam int ADDR_W      = 16;
  localparam int BYTE_W      = 8;

  localparam logic [7:0] TYPE_VEND_OUT = 8'h40;
  localparam logic [7:0] TYPE_VEND_IN  = 8'hC0;
  localparam logic [4:0] OP_PROGRAM    = 5'h01;
  localparam logic [4:0] OP_FETCH      = 5'h02;
  localparam logic [7:0] CODE_IDENT    = 8'h03;
  localparam logic [7:0] CODE_HOLD     = 8'h04;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_PROGRAM,
    CLS_FETCH,
    CLS_IDENT,
    CLS_HOLD,
    CLS_BAD
  } reqClass_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_PROG,
    ST_WAIT_FETCH
  } ctlState_t;

  typedef struct packed {
    logic latchFields;
    logic issueWr;
    logic issueRd;
    logic respFetch;
    logic respEmpty;
    logic respIdent;
    logic setHold;
    logic stall;
  } ctlStrobe_t;

endpackage

// File: rtl/fwdl_control.sv
module fwdl_control
  import fwdl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setupValid,
  input  logic       fwReady,
  input  logic       flashAck,
  input  reqClass_t  reqClass,
  output ctlStrobe_t ctl
);

  ctlState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (setupValid && !fwReady) begin
          unique case (reqClass)
            CLS_PROGRAM: begin
              ctl.latchFields = 1'b1;
              ctl.issueWr     = 1'b1;
              stateNext       = ST_WAIT_PROG;
            end
            CLS_FETCH: begin
              ctl.latchFields = 1'b1;
              ctl.issueRd     = 1'b1;
              stateNext       = ST_WAIT_FETCH;
            end
            CLS_IDENT: ctl.respIdent = 1'b1;
            CLS_HOLD: begin
              ctl.setHold   = 1'b1;
              ctl.respEmpty = 1'b1;
            end
            CLS_BAD:  ctl.stall = 1'b1;
            default:  ;
          endcase
        end
      end
      ST_WAIT_PROG: begin
        if (flashAck) begin
          ctl.respEmpty = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_WAIT_FETCH: begin
        if (flashAck) begin
          ctl.respFetch = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/fwdl_datapath.sv
module fwdl_datapath
  import fwdl_pkg::*;
#(
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*8-1:0] CHIP_ID = 32'h29C51510,
  localparam int RESP_W = ID_BYTES * 8,
  localparam int LEN_W  = $clog2(ID_BYTES + 1)
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [SETUP_BYTES*BYTE_W-1:0] setupBytes,
  input  logic [BYTE_W-1:0]             flashRdData,
  input  ctlStrobe_t                    ctl,
  output reqClass_t                     reqClass,
  output logic                          flashWrReq,
  output logic                          flashRdReq,
  output logic [ADDR_W-1:0]             flashAddr,
  output logic [BYTE_W-1:0]             flashWrData,
  output logic                          respValid,
  output logic [RESP_W-1:0]             respBytes,
  output logic [LEN_W-1:0]              respLen,
  output logic                          holdCpu,
  output logic                          stall
);

  logic [BYTE_W-1:0] sb [SETUP_BYTES];

  genvar g;
  generate
    for (g = 0; g < SETUP_BYTES; g++) begin : g_split
      assign sb[g] = setupBytes[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  logic [7:0]  reqType, reqCode;
  logic [15:0] fValue, fLength;
  logic        isOut, isIn, flashSel, addrOk, dataOk;
  logic [4:0]  opCode;

  assign reqType  = sb[0];
  assign reqCode  = sb[1];
  assign fValue   = {sb[3], sb[2]};
  assign fLength  = {sb[7], sb[6]};
  assign isOut    = (reqType == TYPE_VEND_OUT);
  assign isIn     = (reqType == TYPE_VEND_IN);
  assign flashSel = ~reqCode[7];
  assign addrOk   = reqCode[6];
  assign dataOk   = reqCode[5];
  assign opCode   = reqCode[4:0];

  always_comb begin
    if (!isOut && !isIn)
      reqClass = CLS_NONE;
    else if (isOut && flashSel && addrOk && dataOk && opCode == OP_PROGRAM && fLength == 16'd0)
      reqClass = CLS_PROGRAM;
    else if (isIn && flashSel && addrOk && opCode == OP_FETCH && fLength == 16'd1)
      reqClass = CLS_FETCH;
    else if (isIn && reqCode == CODE_IDENT && fLength == 16'(ID_BYTES))
      reqClass = CLS_IDENT;
    else if (isOut && reqCode == CODE_HOLD)
      reqClass = CLS_HOLD;
    else
      reqClass = CLS_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flashAddr   <= '0;
      flashWrData <= '0;
    end else if (ctl.latchFields) begin
      flashAddr   <= fValue;
      flashWrData <= sb[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flashWrReq <= 1'b0;
      flashRdReq <= 1'b0;
      respValid  <= 1'b0;
      respBytes  <= '0;
      respLen    <= '0;
      holdCpu    <= 1'b0;
      stall      <= 1'b0;
    end else begin
      flashWrReq <= ctl.issueWr;
      flashRdReq <= ctl.issueRd;
      respValid  <= ctl.respIdent | ctl.respFetch | ctl.respEmpty;
      stall      <= ctl.stall;
      holdCpu    <= holdCpu | ctl.setHold;
      if (ctl.respIdent) begin
        respBytes <= CHIP_ID;
        respLen   <= LEN_W'(ID_BYTES);
      end else if (ctl.respFetch) begin
        respBytes <= RESP_W'(flashRdData);
        respLen   <= LEN_W'(1);
      end else if (ctl.respEmpty) begin
        respBytes <= '0;
        respLen   <= '0;
      end
    end
  end

endmodule

// File: rtl/fwdl_setup_decoder.sv
module fwdl_setup_decoder
  import fwdl_pkg::*;
#(
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*8-1:0] CHIP_ID = 32'h29C51510,
  localparam int RESP_W = ID_BYTES * 8,
  localparam int LEN_W  = $clog2(ID_BYTES + 1)
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          setupValid,
  input  logic [SETUP_BYTES*BYTE_W-1:0] setupBytes,
  input  logic                          fwReady,
  input  logic                          flashAck,
  input  logic [BYTE_W-1:0]             flashRdData,
  output logic                          flashWrReq,
  output logic                          flashRdReq,
  output logic [ADDR_W-1:0]             flashAddr,
  output logic [BYTE_W-1:0]             flashWrData,
  output logic                          respValid,
  output logic [RESP_W-1:0]             respBytes,
  output logic [LEN_W-1:0]              respLen,
  output logic                          holdCpu,
  output logic                          stall
);

  reqClass_t  reqClass;
  ctlStrobe_t ctl;

  fwdl_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .setupValid(setupValid),
    .fwReady   (fwReady),
    .flashAck  (flashAck),
    .reqClass  (reqClass),
    .ctl       (ctl)
  );

  fwdl_datapath #(.ID_BYTES(ID_BYTES), .CHIP_ID(CHIP_ID)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .setupBytes (setupBytes),
    .flashRdData(flashRdData),
    .ctl        (ctl),
    .reqClass   (reqClass),
    .flashWrReq (flashWrReq),
    .flashRdReq (flashRdReq),
    .flashAddr  (flashAddr),
    .flashWrData(flashWrData),
    .respValid  (respValid),
    .respBytes  (respBytes),
    .respLen    (respLen),
    .holdCpu    (holdCpu),
    .stall      (stall)
  );

endmodule

// File: rtl/fwdl_checker.sv
module fwdl_checker #(
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*8-1:0] CHIP_ID = 32'h29C51510,
  localparam int RESP_W = ID_BYTES * 8,
  localparam int LEN_W  = $clog2(ID_BYTES + 1)
)(
  input logic              clk,
  input logic              rstN,
  input logic              setupValid,
  input logic              fwReady,
  input logic              flashAck,
  input logic              flashWrReq,
  input logic              flashRdReq,
  input logic              respValid,
  input logic [RESP_W-1:0] respBytes,
  input logic [LEN_W-1:0]  respLen,
  input logic              holdCpu,
  input logic              stall
);

  a_r2_wr_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    flashWrReq |=> !flashWrReq);

  a_r4_rd_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    flashRdReq |=> !flashRdReq);

  a_r7_stall_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  a_r8_stall_needs_hw_control: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> $past(setupValid && !fwReady));

  a_r6_hold_sticky: assert property (@(posedge clk) disable iff (!rstN)
    holdCpu |=> holdCpu);

  a_r5_ident_value: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respLen == LEN_W'(ID_BYTES)) |-> respBytes == CHIP_ID);

  a_r7_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashWrReq, flashRdReq, respValid, stall}));

  a_r3_resp_cause: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(setupValid || flashAck));

endmodule

bind fwdl_setup_decoder fwdl_checker #(.ID_BYTES(ID_BYTES), .CHIP_ID(CHIP_ID)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .setupValid(setupValid),
  .fwReady   (fwReady),
  .flashAck  (flashAck),
  .flashWrReq(flashWrReq),
  .flashRdReq(flashRdReq),
  .respValid (respValid),
  .respBytes (respBytes),
  .respLen   (respLen),
  .holdCpu   (holdCpu),
  .stall     (stall)
);

// File: tb/sim_fwdl_setup_decoder.sv
`timescale 1ns/1ps
module sim_fwdl_setup_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic [63:0] setupBytes = '0;
  logic        fwReady = 1'b0;
  logic        flashAck = 1'b0;
  logic [7:0]  flashRdData = '0;
  logic        flashWrReq, flashRdReq, respValid, holdCpu, stall;
  logic [15:0] flashAddr;
  logic [7:0]  flashWrData;
  logic [31:0] respBytes;
  logic [2:0]  respLen;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fwdl_setup_decoder u0 (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupBytes(setupBytes),
    .fwReady(fwReady), .flashAck(flashAck), .flashRdData(flashRdData),
    .flashWrReq(flashWrReq), .flashRdReq(flashRdReq), .flashAddr(flashAddr),
    .flashWrData(flashWrData), .respValid(respValid), .respBytes(respBytes),
    .respLen(respLen), .holdCpu(holdCpu), .stall(stall)
  );

  function automatic logic [63:0] pkt(input logic [7:0] rt, input logic [7:0] rc,
                                      input logic [15:0] val, input logic [15:0] idx,
                                      input logic [15:0] len);
    return {len, idx, val, rc, rt};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sendSetup(input logic [63:0] b);
    @(negedge clk);
    setupBytes = b;
    setupValid = 1'b1;
    @(negedge clk);
    setupValid = 1'b0;
  endtask

  task automatic giveAck(input logic [7:0] d);
    flashAck    = 1'b1;
    flashRdData = d;
    @(negedge clk);
    flashAck    = 1'b0;
    flashRdData = 8'h00;
  endtask

  task automatic testReset();
    chk("R1 flashWrReq", 32'(flashWrReq), 0);
    chk("R1 flashRdReq", 32'(flashRdReq), 0);
    chk("R1 respValid",  32'(respValid), 0);
    chk("R1 stall",      32'(stall), 0);
    chk("R1 holdCpu",    32'(holdCpu), 0);
  endtask

  task automatic testProgram();
    sendSetup(pkt(8'h40, 8'h61, 16'h1234, 16'h00A5, 16'h0000));
    chk("R2 flashWrReq pulse", 32'(flashWrReq), 1);
    chk("R2 flashAddr", 32'(flashAddr), 32'h1234);
    chk("R2 flashWrData", 32'(flashWrData), 32'hA5);
    tick();
    chk("R2 flashWrReq drops", 32'(flashWrReq), 0);
    chk("R3 no response before ack", 32'(respValid), 0);
    tick();
    chk("R3 still waiting", 32'(respValid), 0);
    giveAck(8'h00);
    chk("R3 respValid after ack", 32'(respValid), 1);
    chk("R3 respLen", 32'(respLen), 0);
    tick();
    chk("R3 respValid single", 32'(respValid), 0);
  endtask

  task automatic testFetch();
    sendSetup(pkt(8'hC0, 8'h62, 16'hBEEF, 16'h0000, 16'h0001));
    chk("R4 flashRdReq pulse", 32'(flashRdReq), 1);
    chk("R4 flashAddr", 32'(flashAddr), 32'hBEEF);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 held until ack", 32'(respValid), 0);
    end
    giveAck(8'h5C);
    chk("R4 respValid", 32'(respValid), 1);
    chk("R4 respLen", 32'(respLen), 1);
    chk("R4 respBytes", respBytes, 32'h5C);
  endtask

  task automatic testIdent();
    sendSetup(pkt(8'hC0, 8'h03, 16'h0000, 16'h0000, 16'h0004));
    chk("R5 respValid", 32'(respValid), 1);
    chk("R5 respLen", 32'(respLen), 4);
    chk("R5 respBytes", respBytes, 32'h29C51510);
    chk("R5 first byte", 32'(respBytes[7:0]), 32'h10);
  endtask

  task automatic testHold();
    sendSetup(pkt(8'h40, 8'h04, 16'h0000, 16'h0000, 16'h0000));
    chk("R6 holdCpu set", 32'(holdCpu), 1);
    chk("R6 respValid", 32'(respValid), 1);
    chk("R6 respLen", 32'(respLen), 0);
    tick(); tick();
    chk("R6 holdCpu sticky", 32'(holdCpu), 1);
  endtask

  task automatic testStall();
    sendSetup(pkt(8'h40, 8'h21, 16'h0100, 16'h0011, 16'h0000));
    chk("R7 stall on addr-valid clear", 32'(stall), 1);
    chk("R7 no write strobe", 32'(flashWrReq), 0);
    tick();
    chk("R7 stall single cycle", 32'(stall), 0);
    sendSetup(pkt(8'hC0, 8'h62, 16'h0100, 16'h0000, 16'h0002));
    chk("R7 stall on bad fetch length", 32'(stall), 1);
    chk("R7 no fetch strobe", 32'(flashRdReq), 0);
  endtask

  task automatic testStandard();
    sendSetup(pkt(8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0012));
    chk("R9 no stall", 32'(stall), 0);
    chk("R9 no response", 32'(respValid), 0);
  endtask

  task automatic testBusy();
    sendSetup(pkt(8'hC0, 8'h62, 16'h0042, 16'h0000, 16'h0001));
    chk("R10 fetch issued", 32'(flashRdReq), 1);
    sendSetup(pkt(8'hC0, 8'h03, 16'h0000, 16'h0000, 16'h0004));
    chk("R10 second setup ignored", 32'(respValid), 0);
    chk("R10 no stall", 32'(stall), 0);
    chk("R10 address kept", 32'(flashAddr), 32'h42);
    giveAck(8'h3D);
    chk("R10 pending completes", 32'(respLen), 1);
    chk("R10 pending data", respBytes, 32'h3D);
  endtask

  task automatic testFwReady();
    fwReady = 1'b1;
    sendSetup(pkt(8'hC0, 8'h03, 16'h0000, 16'h0000, 16'h0004));
    chk("R8 no ident response", 32'(respValid), 0);
    sendSetup(pkt(8'h40, 8'h61, 16'h0007, 16'h0001, 16'h0000));
    chk("R8 no write strobe", 32'(flashWrReq), 0);
    sendSetup(pkt(8'h40, 8'h7F, 16'h0000, 16'h0000, 16'h0000));
    chk("R8 no stall", 32'(stall), 0);
    fwReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testProgram();
    testFetch();
    testIdent();
    testStall();
    testStandard();
    testBusy();
    testHold();
    testFwReady();
    tick();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule